// File: doc/BRIEF.md
# Character Display Output Port

This block sits on a 16-bit memory-mapped bus and hands characters, one at a time, to a slow character display. Software sees two registers. One holds a ready flag and an interrupt enable. The other takes a character.

Software waits for the ready flag, or for the interrupt, and then writes a character. The block sends the low byte to the display with a one-cycle start strobe and becomes busy. It stays busy until the display raises its done input. Reads are combinational from the current address.

The block holds no queue. While it is busy, further characters are dropped, so software must poll the flag or use the interrupt before each write.

Top module: `disp_out_port`

## Requirements
- R1: The status register answers only at address 16'hFE04 and the data register only at 16'hFE06. A write to any other address changes nothing. A read of any other address returns 16'h0000.
- R2: A status read returns the ready flag in bit 15, the interrupt enable in bit 14, and zero in bits 13..0. A write to the status register cannot change the ready flag.
- R3: Only bits 7..0 of an accepted data write reach the display on `dsp_char`. A read of the data register returns 16'h00 in the upper byte and the last accepted character in the lower byte.
- R4: A data write made while ready is 1 clears ready at the next clock edge. At that same edge it raises `dsp_start` for exactly one cycle, with the character already on `dsp_char`.
- R5: While busy, a clock edge that sees `dsp_done` high sets ready back to 1.
- R6: A data write made while ready is 0 is ignored. No start strobe is issued, and `dsp_char` and the stored character keep their values.
- R7: Bit 14 of a status write sets the interrupt enable. `irq` is 1 exactly when ready and enable are both 1.
- R8: After reset, ready is 1, enable is 0, `dsp_start` is 0 and `irq` is 0.
- R9: `dsp_done` seen while ready is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wen | input | 1 | Write strobe, one transfer per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| dsp_start | output | 1 | One-cycle strobe that launches a character |
| dsp_char | output | 8 | Character to display |
| dsp_done | input | 1 | Display reports the character has been shown |
| irq | output | 1 | Interrupt request (ready and enable) |

## Verification
A wrong busy state appears at the ports within one cycle of the event that caused it. A ready flag that is stuck low shows up on the next status read. It also shows up as a missing `irq` right after `dsp_done`. A ready flag that fails to clear lets a second write through, which gives a second start strobe and a new `dsp_char` on the cycle after that write. A wrong byte lane or a wrong address decode shows up on `dsp_char` or in the read data during the same transfer.

// File: rtl/disp_out_pkg.sv
package disp_out_pkg;
  localparam int unsigned DW      = 16;
  localparam int unsigned CW      = 8;
  localparam int unsigned RDY_BIT = 15;
  localparam int unsigned IE_BIT  = 14;

  // Build the status word from the two flags.
  function automatic logic [DW-1:0] pack_status(input logic rdy, input logic ie);
    logic [DW-1:0] w;
    w          = '0;
    w[RDY_BIT] = rdy;
    w[IE_BIT]  = ie;
    return w;
  endfunction

  // Zero-extend a character into a bus word.
  function automatic logic [DW-1:0] pack_char(input logic [CW-1:0] c);
    return {{(DW-CW){1'b0}}, c};
  endfunction
endpackage

// File: rtl/disp_addr_dec.sv
module disp_addr_dec #(
  parameter int unsigned AW        = 16,
  parameter logic [AW-1:0] STAT_AD = 16'hFE04,
  parameter logic [AW-1:0] DATA_AD = 16'hFE06
) (
  input  logic [AW-1:0] addr,
  input  logic          wen,
  output logic          hit_stat,
  output logic          hit_data,
  output logic          wr_stat,
  output logic          wr_data
);
  always_comb begin
    hit_stat = (addr == STAT_AD);
    hit_data = (addr == DATA_AD);
    wr_stat  = wen && hit_stat;
    wr_data  = wen && hit_data;
  end

  // R1: the two register selects never fire together.
  always_comb a_r1_exclusive_sel: assert (!(hit_stat && hit_data));
endmodule

// File: rtl/disp_handshake.sv
module disp_handshake
  import disp_out_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic [CW-1:0] wchar,
  input  logic          done,
  output logic          ready,
  output logic          start,
  output logic [CW-1:0] char_q,
  output logic          accept,
  output logic          finish
);
  always_comb begin
    accept = wr_data && ready;
    finish = done && !ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready  <= 1'b1;
      start  <= 1'b0;
      char_q <= '0;
    end else begin
      start <= accept;
      if (accept) begin
        ready  <= 1'b0;
        char_q <= wchar;
      end else if (finish) begin
        ready <= 1'b1;
      end
    end
  end

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  a_r4_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!ready && start));
  a_r5_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> ready);
  a_r6_char_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(char_q));
  a_r9_done_idle_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !wr_data) |=> ready);
endmodule

// File: rtl/disp_ctrl_regs.sv
module disp_ctrl_regs
  import disp_out_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  logic          ie_in,
  input  logic          hit_stat,
  input  logic          hit_data,
  input  logic          ready,
  input  logic [CW-1:0] char_q,
  output logic          ie,
  output logic          irq,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ie <= 1'b0;
    else if (wr_stat) ie <= ie_in;
  end

  always_comb begin
    irq = ready && ie;
    if (hit_stat)      rdata = pack_status(ready, ie);
    else if (hit_data) rdata = pack_char(char_q);
    else               rdata = '0;
  end

  a_r7_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ready);
  a_r7_ie_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (ie == $past(ie_in)));
endmodule

// File: rtl/disp_out_port.sv
module disp_out_port
  import disp_out_pkg::*;
#(
  parameter logic [15:0] STAT_AD = 16'hFE04,
  parameter logic [15:0] DATA_AD = 16'hFE06
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_wen,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        dsp_start,
  output logic [7:0]  dsp_char,
  input  logic        dsp_done,
  output logic        irq
);
  logic hit_stat, hit_data, wr_stat, wr_data;
  logic ready, accept, finish, ie;

  disp_addr_dec #(.AW(16), .STAT_AD(STAT_AD), .DATA_AD(DATA_AD)) u_dec (
    .addr(bus_addr), .wen(bus_wen), .hit_stat(hit_stat), .hit_data(hit_data),
    .wr_stat(wr_stat), .wr_data(wr_data)
  );

  disp_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wchar(bus_wdata[CW-1:0]),
    .done(dsp_done), .ready(ready), .start(dsp_start), .char_q(dsp_char),
    .accept(accept), .finish(finish)
  );

  disp_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .ie_in(bus_wdata[IE_BIT]),
    .hit_stat(hit_stat), .hit_data(hit_data), .ready(ready), .char_q(dsp_char),
    .ie(ie), .irq(irq), .rdata(bus_rdata)
  );

  // R6: a write while busy never launches a character.
  a_r6_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !ready) |=> !dsp_start);
  // R2: a status write leaves the ready flag alone.
  a_r2_stat_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !dsp_done) |=> (ready == $past(ready)));
endmodule

// File: tb/sim_disp_out_port.sv
module sim_disp_out_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic        bus_wen = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        dsp_start;
  logic [7:0]  dsp_char;
  logic        dsp_done = 1'b0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  localparam logic [15:0] A_ST = 16'hFE04;
  localparam logic [15:0] A_DT = 16'hFE06;

  always #10 clk = ~clk;

  disp_out_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dsp_start(dsp_start),
    .dsp_char(dsp_char), .dsp_done(dsp_done), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] wval;
    logic [7:0]  exp_char;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'h1241, 8'h41}, '{16'hFF7E, 8'h7E}, '{16'h0000, 8'h00},
    '{16'hA5C3, 8'hC3}, '{16'h80FF, 8'hFF}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_done();
    dsp_done = 1'b1;
    @(negedge clk);
    dsp_done = 1'b0;
  endtask

  // Expected status word: ready in bit 15, enable in bit 14.
  function automatic logic [15:0] st_word(input bit r, input bit e);
    return (r ? 16'h8000 : 16'h0000) | (e ? 16'h4000 : 16'h0000);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    bus_read(A_ST, rd); check("R8 status", rd, st_word(1, 0));
    check("R8 irq", {15'b0, irq}, 16'h0);
    check("R8 start", {15'b0, dsp_start}, 16'h0);

    // Table walk: R3 R4 R5
    for (int i = 0; i < 5; i++) begin
      bus_write(A_DT, VECS[i].wval);
      check("R4 start pulse", {15'b0, dsp_start}, 16'h1);
      check("R3 low byte", {8'h0, dsp_char}, {8'h0, VECS[i].exp_char});
      bus_read(A_ST, rd); check("R4 busy", rd, st_word(0, 0));
      @(negedge clk);
      check("R4 single pulse", {15'b0, dsp_start}, 16'h0);
      bus_read(A_DT, rd); check("R3 data readback", rd, {8'h0, VECS[i].exp_char});
      pulse_done();
      bus_read(A_ST, rd); check("R5 ready back", rd, st_word(1, 0));
    end

    // R6 write while busy
    bus_write(A_DT, 16'h0031);
    @(negedge clk);
    bus_write(A_DT, 16'h0032);
    check("R6 no start", {15'b0, dsp_start}, 16'h0);
    check("R6 char kept", {8'h0, dsp_char}, 16'h0031);
    bus_read(A_DT, rd); check("R6 stored kept", rd, 16'h0031);
    pulse_done();

    // R9 done while idle
    pulse_done();
    bus_read(A_ST, rd); check("R9 ready kept", rd, st_word(1, 0));
    check("R9 no start", {15'b0, dsp_start}, 16'h0);

    // R2 status write cannot clear ready
    bus_write(A_ST, 16'h0000);
    bus_read(A_ST, rd); check("R2 ready not writable", rd, st_word(1, 0));

    // R7 interrupt enable
    bus_write(A_ST, 16'h4000);
    bus_read(A_ST, rd); check("R7 ie set", rd, st_word(1, 1));
    check("R7 irq on", {15'b0, irq}, 16'h1);
    bus_write(A_DT, 16'h0050);
    check("R7 irq off busy", {15'b0, irq}, 16'h0);
    pulse_done();
    check("R7 irq after done", {15'b0, irq}, 16'h1);
    bus_write(A_ST, 16'hBFFF);
    check("R7 irq cleared", {15'b0, irq}, 16'h0);

    // R1 other addresses
    bus_write(16'hFE05, 16'h0077);
    check("R1 no start odd addr", {15'b0, dsp_start}, 16'h0);
    bus_write(16'hFE02, 16'h4000);
    bus_read(A_ST, rd); check("R1 no effect", rd, st_word(1, 0));
    bus_read(16'hFE00, rd); check("R1 unmapped read", rd, 16'h0000);
    check("R1 char kept", {8'h0, dsp_char}, 16'h0050);

    // R8 reset in mid transfer
    bus_write(A_ST, 16'h4000);
    bus_write(A_DT, 16'h0061);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bus_read(A_ST, rd); check("R8 reset restores", rd, st_word(1, 0));
    check("R8 irq after reset", {15'b0, irq}, 16'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule